// File: doc/BRIEF.md
# Key-Protected Control Register Bank

A 32-bit register bank for a system controller, reached through a simple synchronous bus that uses a byte address, a write strobe and a read strobe. Software must first write a magic value to the unlock register. Until it does, every other register refuses writes. Reset-control and clock-gate-control registers are changed only by bit-set and bit-clear operations. Each of them has a set address and a clear alias at the next word. This lets software touch single bits without a read-modify-write.

Two strap registers start from the strap input pins. Software can add bits to them until their guard register is written nonzero. Once that happens, set-writes to the strap are dropped. Clear-writes to the strap are still accepted. The bank also holds:

- read-only revision and identity words;
- three PLL status words that always report lock;
- a random word that produces a new LFSR value on every read.

Read data is registered.

Top module: `keyed_ctl_bank`

## Requirements
- R1: Writing byte address 0x00 stores 1 when the data equals KEY_MAGIC (default 0xC0DE5A17) and 0 otherwise. A read of 0x00 returns the stored bit in bit 0 and zeros above it.
- R2: While the unlock bit is 0, writes to every address other than 0x00 leave all state unchanged.
- R3: A write to a gate word at 0x14, 0x1C, 0x24 or 0x2C ORs the data into the stored value.
- R4: A write to the clear alias 4 bytes above a gate word clears the bits of that word where the data is 1. Clear aliases read as 0.
- R5: A write to a strap word (0x34 or 0x40) ORs in the data. It is dropped when the guard word 8 bytes above the strap is nonzero. The strap clear alias at +4 always takes effect.
- R6: Writes to the revision words (0x04, 0x08), the identity words (0x0C = CHIP_LO, 0x10 = CHIP_HI) and the random word (0x60) are ignored.
- R7: A read of a PLL status word (0x50, 0x54, 0x58) returns the stored value with bit 31 forced to 1.
- R8: Each read of 0x60 advances a 32-bit LFSR from seed LFSR_SEED using next = (s >> 1) ^ (s[0] ? 0x80200003 : 0), and returns the new value. The value in the random-control word at 0x5C has no effect on this.
- R9: An access whose address bits [1:0] are not 00, or whose address lies above 0x60, reads 0 and writes nothing. A misaligned read does not advance the LFSR.
- R10: On reset the following load:
  - the gate words and other registers take their default parameters;
  - both revision words take `rev_in`;
  - the straps take `strap_a_in` and `strap_b_in`;
  - the guards become 0;
  - the unlock bit takes `unlock_preset`;
  - `rd_data` becomes 0.
- R11: `rd_data` presents the addressed value one clock after `rd_en` is sampled high, and holds that value while `rd_en` stays low.
- R12: The PLL parameter word (0x4C), the random-control word (0x5C) and the guard words store and return full 32-bit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rev_in | input | 32 | Revision value loaded at reset |
| strap_a_in | input | 32 | Reset value of strap word A |
| strap_b_in | input | 32 | Reset value of strap word B |
| unlock_preset | input | 1 | Reset value of the unlock bit |

## Verification
The bench targets the points where a plausible design goes wrong:

- **Set and clear aliases off by one word.** A clear at 0x18 would then hit the wrong register, or overwrite instead of masking.
- **Guarded strap also blocking clears.** The bench clears a guarded strap and expects the clear to take effect.
- **Locked bank still accepting writes.** After a wrong key, the bench writes a gate word and expects it unchanged.
- **PLL status without forced lock bit.** A status word read must show bit 31 set even when 0 was stored there.

It also checks that the random word steps exactly once per aligned read, and that it ignores the control word and misaligned reads. Finally, it resets a second time with different pins and checks that the unlock bit and straps come from those pins, not from the previous state.

// File: rtl/keyed_ctl_bank.sv
module keyed_ctl_bank #(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] KEY_MAGIC  = 32'hC0DE_5A17,
  parameter logic [3:0][31:0] GATE_RST = {32'h00F0_F00F, 32'h7F7F_0A8A, 32'hFFFF_FF0C, 32'hF0C3_3E18},
  parameter logic [31:0] PLL_RST    = 32'h2000_41A3,
  parameter logic [31:0] RNGC_RST   = 32'h0000_000C,
  parameter logic [31:0] CHIP_LO    = 32'h5EED_0001,
  parameter logic [31:0] CHIP_HI    = 32'hB10C_2222,
  parameter logic [31:0] LFSR_SEED  = 32'hACE1_ACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [31:0]       rev_in,
  input  logic [31:0]       strap_a_in,
  input  logic [31:0]       strap_b_in,
  input  logic              unlock_preset
);

  localparam int IDXW    = ADDR_W - 2;
  localparam int N_GATE  = 4;
  localparam int N_STRAP = 2;
  localparam int N_PLLX  = 3;
  localparam int W_KEY   = 0;
  localparam int W_REVA  = 1;
  localparam int W_REVB  = 2;
  localparam int W_IDLO  = 3;
  localparam int W_IDHI  = 4;
  localparam int W_GATE  = 5;
  localparam int W_STRAP = W_GATE + 2 * N_GATE;
  localparam int W_PLL   = W_STRAP + 3 * N_STRAP;
  localparam int W_PLLX  = W_PLL + 1;
  localparam int W_RNGC  = W_PLLX + N_PLLX;
  localparam int W_RNGD  = W_RNGC + 1;
  localparam int WORDS   = W_RNGD + 1;
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  logic [IDXW-1:0] widx;
  logic            aligned, in_rng, wr_ok, rng_hit;
  logic            key_q;
  logic [31:0]     rev_q, pll_q, rngc_q, lfsr_q, lfsr_nx, rd_mux;
  logic [N_GATE-1:0][31:0]  gate_q;
  logic [N_STRAP-1:0][31:0] strap_q, guard_q;
  logic [N_PLLX-1:0][31:0]  pllx_q;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign in_rng  = (widx < IDXW'(WORDS));
  assign wr_ok   = wr_en && aligned && in_rng && (key_q || widx == IDXW'(W_KEY));
  assign rng_hit = rd_en && aligned && (widx == IDXW'(W_RNGD));
  assign lfsr_nx = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? LFSR_TAPS : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= unlock_preset;
      rev_q   <= rev_in;
      pll_q   <= PLL_RST;
      rngc_q  <= RNGC_RST;
      lfsr_q  <= LFSR_SEED;
      gate_q  <= GATE_RST;
      strap_q <= {strap_b_in, strap_a_in};
      guard_q <= '0;
      pllx_q  <= '0;
    end else begin
      if (rng_hit) lfsr_q <= lfsr_nx;
      if (wr_ok) begin
        if (widx == IDXW'(W_KEY))  key_q  <= (wr_data == KEY_MAGIC);
        if (widx == IDXW'(W_PLL))  pll_q  <= wr_data;
        if (widx == IDXW'(W_RNGC)) rngc_q <= wr_data;
        for (int i = 0; i < N_GATE; i++) begin
          if (widx == IDXW'(W_GATE + 2*i))     gate_q[i] <= gate_q[i] | wr_data;
          if (widx == IDXW'(W_GATE + 2*i + 1)) gate_q[i] <= gate_q[i] & ~wr_data;
        end
        for (int i = 0; i < N_STRAP; i++) begin
          if (widx == IDXW'(W_STRAP + 3*i) && guard_q[i] == 32'h0)
            strap_q[i] <= strap_q[i] | wr_data;
          if (widx == IDXW'(W_STRAP + 3*i + 1)) strap_q[i] <= strap_q[i] & ~wr_data;
          if (widx == IDXW'(W_STRAP + 3*i + 2)) guard_q[i] <= wr_data;
        end
        for (int i = 0; i < N_PLLX; i++)
          if (widx == IDXW'(W_PLLX + i)) pllx_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_mux = 32'h0;
    if (widx == IDXW'(W_KEY))  rd_mux = {31'h0, key_q};
    if (widx == IDXW'(W_REVA) || widx == IDXW'(W_REVB)) rd_mux = rev_q;
    if (widx == IDXW'(W_IDLO)) rd_mux = CHIP_LO;
    if (widx == IDXW'(W_IDHI)) rd_mux = CHIP_HI;
    if (widx == IDXW'(W_PLL))  rd_mux = pll_q;
    if (widx == IDXW'(W_RNGC)) rd_mux = rngc_q;
    if (widx == IDXW'(W_RNGD)) rd_mux = lfsr_nx;
    for (int i = 0; i < N_GATE; i++)
      if (widx == IDXW'(W_GATE + 2*i)) rd_mux = gate_q[i];
    for (int i = 0; i < N_STRAP; i++) begin
      if (widx == IDXW'(W_STRAP + 3*i))     rd_mux = strap_q[i];
      if (widx == IDXW'(W_STRAP + 3*i + 2)) rd_mux = guard_q[i];
    end
    for (int i = 0; i < N_PLLX; i++)
      if (widx == IDXW'(W_PLLX + i)) rd_mux = pllx_q[i] | 32'h8000_0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 32'h0;
    else if (rd_en) rd_data <= (aligned && in_rng) ? rd_mux : 32'h0;
  end

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_q && widx != IDXW'(W_KEY)) |=> ($stable(gate_q) && $stable(strap_q) && $stable(pll_q)));

  // R3
  gate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_q && aligned && widx == IDXW'(W_GATE)) |=> ((gate_q[0] & $past(wr_data)) == $past(wr_data)));

  // R4
  gate_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_q && aligned && widx == IDXW'(W_GATE + 1)) |=> ((gate_q[0] & $past(wr_data)) == 32'h0));

  // R5
  strap_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && aligned && widx == IDXW'(W_STRAP) && guard_q[0] != 32'h0) |=> $stable(strap_q[0]));

  // R7
  pll_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && aligned && widx >= IDXW'(W_PLLX) && widx < IDXW'(W_PLLX + N_PLLX)) |=> rd_data[31]);

  // R9
  outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (!aligned || !in_rng)) |=> (rd_data == 32'h0));

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 32'h0);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/test_keyed_ctl_bank.sv
module test_keyed_ctl_bank;
  localparam logic [31:0] KEY  = 32'hC0DE_5A17;
  localparam logic [31:0] SEED = 32'hACE1_ACE1;
  localparam logic [31:0] REV  = 32'h0503_0303;
  localparam int NV = 49;
  // {req(4), write(1), addr(8), data(32), expected(32)}
  localparam logic [76:0] VEC [NV] = '{
    {4'd10, 1'b0, 8'h00, 32'h0, 32'h0000_0001},   // R10 preset unlock
    {4'd10, 1'b0, 8'h04, 32'h0, REV},             // R10 revision A
    {4'd10, 1'b0, 8'h08, 32'h0, REV},             // R10 revision B
    {4'd6,  1'b0, 8'h0C, 32'h0, 32'h5EED_0001},   // R6 id low
    {4'd10, 1'b0, 8'h14, 32'h0, 32'hF0C3_3E18},   // R10 gate default
    {4'd3,  1'b1, 8'h14, 32'h0000_0007, 32'h0},
    {4'd3,  1'b0, 8'h14, 32'h0, 32'hF0C3_3E1F},   // R3
    {4'd4,  1'b1, 8'h18, 32'hF000_0001, 32'h0},
    {4'd4,  1'b0, 8'h14, 32'h0, 32'h00C3_3E1E},   // R4
    {4'd3,  1'b1, 8'h1C, 32'h0000_00F0, 32'h0},
    {4'd3,  1'b0, 8'h1C, 32'h0, 32'hFFFF_FFFC},   // R3
    {4'd4,  1'b1, 8'h30, 32'hFFFF_0000, 32'h0},
    {4'd4,  1'b0, 8'h2C, 32'h0, 32'h0000_F00F},   // R4
    {4'd10, 1'b0, 8'h34, 32'h0, 32'h0000_1111},   // R10 strap A pins
    {4'd5,  1'b1, 8'h34, 32'h0000_2200, 32'h0},
    {4'd5,  1'b0, 8'h34, 32'h0, 32'h0000_3311},   // R5 set
    {4'd5,  1'b1, 8'h38, 32'h0000_0011, 32'h0},
    {4'd5,  1'b0, 8'h34, 32'h0, 32'h0000_3300},   // R5 clear
    {4'd12, 1'b1, 8'h3C, 32'h0000_0001, 32'h0},
    {4'd12, 1'b0, 8'h3C, 32'h0, 32'h0000_0001},   // R12 guard
    {4'd5,  1'b1, 8'h34, 32'hFFFF_0000, 32'h0},
    {4'd5,  1'b0, 8'h34, 32'h0, 32'h0000_3300},   // R5 guarded
    {4'd5,  1'b1, 8'h38, 32'h0000_0300, 32'h0},
    {4'd5,  1'b0, 8'h34, 32'h0, 32'h0000_3000},   // R5 clear while guarded
    {4'd10, 1'b0, 8'h40, 32'h0, 32'h2200_0000},   // R10 strap B pins
    {4'd5,  1'b1, 8'h40, 32'h0000_0011, 32'h0},
    {4'd5,  1'b0, 8'h40, 32'h0, 32'h2200_0011},   // R5 strap B open
    {4'd6,  1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {4'd6,  1'b0, 8'h04, 32'h0, REV},             // R6
    {4'd6,  1'b1, 8'h10, 32'h0, 32'h0},
    {4'd6,  1'b0, 8'h10, 32'h0, 32'hB10C_2222},   // R6
    {4'd7,  1'b1, 8'h50, 32'h0000_1234, 32'h0},
    {4'd7,  1'b0, 8'h50, 32'h0, 32'h8000_1234},   // R7
    {4'd7,  1'b0, 8'h58, 32'h0, 32'h8000_0000},   // R7
    {4'd12, 1'b1, 8'h4C, 32'hDEAD_BEEF, 32'h0},
    {4'd12, 1'b0, 8'h4C, 32'h0, 32'hDEAD_BEEF},   // R12
    {4'd4,  1'b0, 8'h18, 32'h0, 32'h0},           // R4 alias reads 0
    {4'd9,  1'b0, 8'h64, 32'h0, 32'h0},           // R9 above range
    {4'd9,  1'b0, 8'hFC, 32'h0, 32'h0},           // R9
    {4'd9,  1'b1, 8'h15, 32'hFFFF_FFFF, 32'h0},
    {4'd9,  1'b0, 8'h14, 32'h0, 32'h00C3_3E1E},   // R9 misaligned write
    {4'd9,  1'b0, 8'h15, 32'h0, 32'h0},           // R9 misaligned read
    {4'd1,  1'b1, 8'h00, 32'h0000_1234, 32'h0},
    {4'd1,  1'b0, 8'h00, 32'h0, 32'h0},           // R1 bad key
    {4'd2,  1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
    {4'd2,  1'b0, 8'h14, 32'h0, 32'h00C3_3E1E},   // R2
    {4'd1,  1'b1, 8'h00, KEY, 32'h0},
    {4'd1,  1'b0, 8'h00, 32'h0, 32'h0000_0001},   // R1 good key
    {4'd12, 1'b0, 8'h4C, 32'h0, 32'hDEAD_BEEF}    // R12 kept through lock
  };

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, unlock_preset = 1;
  logic [7:0]  addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [31:0] rev_in = REV, strap_a_in = 32'h0000_1111, strap_b_in = 32'h2200_0000;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  keyed_ctl_bank i_keyed_ctl_bank (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rev_in(rev_in),
    .strap_a_in(strap_a_in), .strap_b_in(strap_b_in), .unlock_preset(unlock_preset));

  function automatic logic [31:0] step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, m;
    repeat (3) @(negedge clk);
    check("R10 rd_data reset", rd_data, 32'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], v);
        check($sformatf("R%0d vector %0d", VEC[i][76:73], i), v, VEC[i][31:0]);
      end
    end
    // R8 random word
    m = SEED;
    for (int k = 0; k < 3; k++) begin
      rd(8'h60, v); m = step(m); check("R8 lfsr step", v, m);
    end
    wr(8'h5C, 32'h0);
    rd(8'h60, v); m = step(m); check("R8 control ignored", v, m);
    wr(8'h60, 32'h0);
    rd(8'h60, v); m = step(m); check("R6 random write ignored", v, m);
    rd(8'h61, v); check("R9 misaligned random read", v, 32'h0);
    rd(8'h60, v); m = step(m); check("R9 no advance on misaligned", v, m);
    // R11 latency and hold
    @(negedge clk); addr = 8'h08; rd_en = 1;
    @(posedge clk); #1; check("R11 valid after one clock", rd_data, REV);
    @(negedge clk); rd_en = 0; addr = 8'h14;
    repeat (3) @(negedge clk);
    check("R11 hold while idle", rd_data, REV);
    // R10 second reset with other pins
    unlock_preset = 0; strap_a_in = 32'hA5A5_0000; rev_in = 32'h0000_0777;
    @(negedge clk); rst_n = 0;
    @(negedge clk); check("R10 rd_data cleared", rd_data, 32'h0);
    rst_n = 1;
    rd(8'h00, v); check("R10 unlock from pin", v, 32'h0);
    rd(8'h34, v); check("R10 strap reload", v, 32'hA5A5_0000);
    rd(8'h3C, v); check("R10 guard cleared", v, 32'h0);
    rd(8'h04, v); check("R10 revision reload", v, 32'h0000_0777);
    rd(8'h14, v); check("R10 gate default", v, 32'hF0C3_3E18);
    rd(8'h60, v); check("R10 lfsr reseed", v, step(SEED));
    wr(8'h34, 32'h0000_00FF);
    rd(8'h34, v); check("R2 strap locked", v, 32'hA5A5_0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule